// File: doc/BRIEF.md
# Buck Power-Stage Gate Sequencer

This block is the clocked control core of a synchronous buck power stage. It takes a three-level PWM command and a three-level skip-mode command, both already turned into 2-bit codes by external comparators. From them it produces the two gate commands: one for the high-side switch and one for the low-side switch. Sensed analog levels arrive as single-bit flags: the low-side gate has fallen below 1 V, the switch node has fallen below 1 V, and the switch node has crossed the zero-current threshold. The block uses these flags to enforce adaptive break-before-make timing between the two switches.

A mid-level PWM code is taken as "tri-state" only after it has been stable for a holdoff window, so short glitches are filtered out. What happens next depends on the skip-mode level. With skip-mode high or mid, the low side stays on through a blanking window and then turns off at the zero crossing; this is diode emulation. With skip-mode low, both switches are released at once. The block also handles the power-up enable delay, an active-low disable input, and forced shutdown on a supply or temperature fault. Every delay is set by a parameter in nanoseconds and converted to clock cycles, rounding up, from a clock-period parameter.

The controller is a Moore state machine with seven states:
- ST_OFF: both gates off, not running.
- ST_LS_ON: low side conducting.
- ST_HS_GAP: dead time before the high side turns on.
- ST_HS_ON: high side conducting.
- ST_LS_GAP: dead time before the low side turns on.
- ST_ZC_BLANK: low side on in diode emulation, waiting out the blanking window and then the zero crossing.
- ST_TRI_OFF: both gates released in tri-state.

Transitions:
- Loss of run permission sends any state to ST_OFF.
- A high command enters ST_HS_GAP from every state except ST_HS_ON and ST_HS_GAP.
- ST_HS_GAP moves to ST_HS_ON on expiry.
- A low command moves ST_HS_ON, ST_HS_GAP, ST_OFF and ST_TRI_OFF to ST_LS_GAP, and moves ST_ZC_BLANK back to ST_LS_ON.
- ST_LS_GAP goes to ST_LS_ON on expiry, or to ST_ZC_BLANK on expiry while the filtered command is mid.
- A mid command:
  - moves ST_LS_ON to ST_ZC_BLANK;
  - moves ST_HS_ON and ST_HS_GAP to ST_LS_GAP;
  - moves ST_OFF to ST_TRI_OFF;
  - with skip-mode low, moves every running state to ST_TRI_OFF.
- ST_ZC_BLANK goes to ST_TRI_OFF on the zero crossing once blanking is over.

Top module: `gdrv_sequencer`

## Requirements
- R1: While `disable_n` is sampled low, both gate outputs are low from the first clock edge that samples it; after reset both outputs are low.
- R2: After `disable_n` is first sampled high, the block stays off for EN_CYC clock edges. With a high PWM command and `lsg_low` asserted, `hs_gate` rises at edge EN_CYC+DH_CYC+2.
- R3: Code mapping is 00 low, 01 mid, 10 high and 11 mid, for both PWM and skip. In steady state:
  - PWM high gives hs=1, ls=0.
  - PWM low gives hs=0, ls=1, for every skip code.
  - PWM mid with no zero crossing gives hs=0, ls=1 when skip is high or mid, and hs=0, ls=0 when skip is low.
- R4: `hs_gate` and `ls_gate` are never high in the same cycle.
- R5: After a low-to-high PWM change, `ls_gate` falls at edge 2. `hs_gate` rises only after `lsg_low` has been sampled high on DH_CYC consecutive edges, one edge after the last of them.
- R6: After a high-to-low PWM change, `hs_gate` falls at edge 2. `ls_gate` rises only after `sw_low` has been sampled high on DL_CYC consecutive edges, one edge after the last of them.
- R7: A mid PWM code must be sampled on HOLD_CYC consecutive edges before it takes effect; a shorter mid run leaves the outputs unchanged.
- R8: In tri-state with skip high or mid, coming from the low-side-on state, `ls_gate` stays high through edge HOLD_CYC+BLANK_CYC+1 and falls on the first later edge at which `sw_zc` is sampled high. It stays high indefinitely if `sw_zc` never rises.
- R9: In tri-state with skip low, both outputs are low from edge HOLD_CYC+1 after the mid code first appears, with no blanking.
- R10: The skip code is frozen while `hs_gate` is high. A skip change made during the high-side on-time does not alter the tri-state decision taken when the high side turns off.
- R11: Sampling `supply_ok` low or `over_temp` high drives both outputs low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_n | input | 1 | Active-low stage disable |
| supply_ok | input | 1 | Supply above lockout threshold |
| over_temp | input | 1 | Over-temperature flag |
| pwm_code | input | 2 | PWM level code (00 low, 01 mid, 10 high, 11 mid) |
| skip_code | input | 2 | Skip-mode level code, same encoding |
| lsg_low | input | 1 | Low-side gate sensed below 1 V |
| sw_low | input | 1 | Switch node sensed below 1 V |
| sw_zc | input | 1 | Switch node past zero-cross threshold |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
A sweep runs all sixteen PWM and skip code pairs from a settled low-side-on state. It separates the direct on/off commands from the two tri-state outcomes, and shows whether code 11 behaves like mid and whether skip mid behaves like skip high. Directed sequences then hold each sense flag low to show that a dead time truly waits on it. Other sequences apply a mid glitch one cycle shorter than the holdoff, which must leave the outputs alone. Zero crossings arrive both early and long after blanking, which separates blanking from plain detection. Finally, a skip change made during high-side conduction must not reroute the following tri-state into diode emulation.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LS_ON,
        ST_HS_GAP,
        ST_HS_ON,
        ST_LS_GAP,
        ST_ZC_BLANK,
        ST_TRI_OFF
    } st_e;

    // Code 11 is treated as mid.
    function automatic lvl_e decode_lvl(input logic [1:0] code);
        lvl_e v;
        case (code)
            2'b00:   v = LVL_LOW;
            2'b10:   v = LVL_HIGH;
            default: v = LVL_MID;
        endcase
        return v;
    endfunction

    // Nanoseconds to clock cycles, rounded up, at least one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/gdrv_tick_timer.sv
module gdrv_tick_timer #(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int unsigned W = (N < 1) ? 1 : $clog2(N + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != W'(N)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == W'(N));
endmodule

// File: rtl/gdrv_level_filter.sv
module gdrv_level_filter
    import gdrv_pkg::*;
#(
    parameter int unsigned HOLD = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_in,
    output lvl_e       lvl_out
);
    localparam int unsigned W = (HOLD < 1) ? 1 : $clog2(HOLD + 1);

    lvl_e         raw;
    logic [W-1:0] hcnt;

    assign raw = decode_lvl(code_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_out <= LVL_LOW;
            hcnt    <= '0;
        end else if (raw != LVL_MID) begin
            lvl_out <= raw;
            hcnt    <= '0;
        end else if (lvl_out != LVL_MID) begin
            if (hcnt == W'(HOLD - 1)) begin
                lvl_out <= LVL_MID;
                hcnt    <= '0;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gdrv_enable_gate.sv
module gdrv_enable_gate #(
    parameter int unsigned EN_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_n,
    input  logic supply_ok,
    input  logic over_temp,
    output logic run
);
    localparam int unsigned W = $clog2(EN_CYC + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!disable_n) begin
            cnt <= '0;
        end else if (cnt != W'(EN_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign run = disable_n && supply_ok && !over_temp && (cnt == W'(EN_CYC));
endmodule

// File: rtl/gdrv_sequencer.sv
module gdrv_sequencer
    import gdrv_pkg::*;
#(
    parameter int unsigned CLK_PS      = 20000,
    parameter int unsigned EN_DELAY_NS = 40000,
    parameter int unsigned HOLD_NS     = 330,
    parameter int unsigned BLANK_NS    = 300,
    parameter int unsigned DT_HS_NS    = 13,
    parameter int unsigned DT_LS_NS    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       disable_n,
    input  logic       supply_ok,
    input  logic       over_temp,
    input  logic [1:0] pwm_code,
    input  logic [1:0] skip_code,
    input  logic       lsg_low,
    input  logic       sw_low,
    input  logic       sw_zc,
    output logic       hs_gate,
    output logic       ls_gate
);
    localparam int unsigned EN_CYC    = ns_to_cyc(EN_DELAY_NS, CLK_PS);
    localparam int unsigned HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_PS);
    localparam int unsigned BLANK_CYC = ns_to_cyc(BLANK_NS, CLK_PS);
    localparam int unsigned DH_CYC    = ns_to_cyc(DT_HS_NS, CLK_PS);
    localparam int unsigned DL_CYC    = ns_to_cyc(DT_LS_NS, CLK_PS);

    st_e  st, nxt;
    lvl_e pwm_f;
    lvl_e skip_q;
    logic run;
    logic hs_dt_done, ls_dt_done, blank_done;
    logic skip_low;

    gdrv_enable_gate #(.EN_CYC(EN_CYC)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .disable_n (disable_n),
        .supply_ok (supply_ok),
        .over_temp (over_temp),
        .run       (run)
    );

    gdrv_level_filter #(.HOLD(HOLD_CYC)) u_pwm_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (pwm_code),
        .lvl_out (pwm_f)
    );

    // Dead time before high side: restarts whenever the low-side gate sense drops.
    gdrv_tick_timer #(.N(DH_CYC)) u_hs_dt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((st != ST_HS_GAP) || !lsg_low),
        .expired (hs_dt_done)
    );

    // Dead time before low side: restarts whenever the switch-node sense drops.
    gdrv_tick_timer #(.N(DL_CYC)) u_ls_dt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((st != ST_LS_GAP) || !sw_low),
        .expired (ls_dt_done)
    );

    // Zero-cross blanking window while emulating a diode.
    gdrv_tick_timer #(.N(BLANK_CYC)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st != ST_ZC_BLANK),
        .expired (blank_done)
    );

    // Skip level is captured only while the high side is not conducting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q <= LVL_HIGH;
        end else if (st != ST_HS_ON) begin
            skip_q <= decode_lvl(skip_code);
        end
    end

    assign skip_low = (skip_q == LVL_LOW);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = st;
        if (!run) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF: begin
                    if (pwm_f == LVL_HIGH)     nxt = ST_HS_GAP;
                    else if (pwm_f == LVL_LOW) nxt = ST_LS_GAP;
                    else                       nxt = ST_TRI_OFF;
                end
                ST_LS_ON: begin
                    if (pwm_f == LVL_HIGH)     nxt = ST_HS_GAP;
                    else if (pwm_f == LVL_MID) nxt = skip_low ? ST_TRI_OFF : ST_ZC_BLANK;
                end
                ST_HS_GAP: begin
                    if (pwm_f == LVL_LOW)      nxt = ST_LS_GAP;
                    else if (pwm_f == LVL_MID) nxt = skip_low ? ST_TRI_OFF : ST_LS_GAP;
                    else if (hs_dt_done)       nxt = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (pwm_f == LVL_LOW)      nxt = ST_LS_GAP;
                    else if (pwm_f == LVL_MID) nxt = skip_low ? ST_TRI_OFF : ST_LS_GAP;
                end
                ST_LS_GAP: begin
                    if (pwm_f == LVL_HIGH)                 nxt = ST_HS_GAP;
                    else if (pwm_f == LVL_MID && skip_low) nxt = ST_TRI_OFF;
                    else if (ls_dt_done)
                        nxt = (pwm_f == LVL_MID) ? ST_ZC_BLANK : ST_LS_ON;
                end
                ST_ZC_BLANK: begin
                    if (pwm_f == LVL_HIGH)        nxt = ST_HS_GAP;
                    else if (pwm_f == LVL_LOW)    nxt = ST_LS_ON;
                    else if (skip_low)            nxt = ST_TRI_OFF;
                    else if (blank_done && sw_zc) nxt = ST_TRI_OFF;
                end
                ST_TRI_OFF: begin
                    if (pwm_f == LVL_HIGH)     nxt = ST_HS_GAP;
                    else if (pwm_f == LVL_LOW) nxt = ST_LS_GAP;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Moore outputs.
    always_comb begin
        hs_gate = 1'b0;
        ls_gate = 1'b0;
        unique case (st)
            ST_HS_ON:              hs_gate = 1'b1;
            ST_LS_ON, ST_ZC_BLANK: ls_gate = 1'b1;
            default: begin
                hs_gate = 1'b0;
                ls_gate = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gdrv_sequencer_chk.sv
module gdrv_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic disable_n,
    input logic supply_ok,
    input logic over_temp,
    input logic lsg_low,
    input logic sw_low,
    input logic hs_gate,
    input logic ls_gate
);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disable_n |=> (!hs_gate && !ls_gate));

    a_r11_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || over_temp) |=> (!hs_gate && !ls_gate));

    a_r5_hs_waits_ls_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(lsg_low, 2));

    a_r6_ls_waits_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> $past(sw_low, 2));
endmodule

bind gdrv_sequencer gdrv_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .disable_n (disable_n),
    .supply_ok (supply_ok),
    .over_temp (over_temp),
    .lsg_low   (lsg_low),
    .sw_low    (sw_low),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
);

// File: tb/tb_gdrv_sequencer.sv
module tb_gdrv_sequencer;
    localparam int unsigned CLK_PS = 20000;
    localparam int unsigned EN_NS  = 400;
    localparam int unsigned HLD_NS = 100;
    localparam int unsigned BLK_NS = 100;
    localparam int unsigned DH_NS  = 40;
    localparam int unsigned DL_NS  = 60;

    localparam int EN = (EN_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int H  = (HLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int B  = (BLK_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int DH = (DH_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int DL = (DL_NS  * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n, disable_n, supply_ok, over_temp, lsg_low, sw_low, sw_zc;
    logic [1:0] pwm_code, skip_code;
    logic hs_gate, ls_gate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10ns clk = ~clk;

    gdrv_sequencer #(
        .CLK_PS(CLK_PS), .EN_DELAY_NS(EN_NS), .HOLD_NS(HLD_NS),
        .BLANK_NS(BLK_NS), .DT_HS_NS(DH_NS), .DT_LS_NS(DL_NS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .disable_n(disable_n), .supply_ok(supply_ok),
        .over_temp(over_temp), .pwm_code(pwm_code), .skip_code(skip_code),
        .lsg_low(lsg_low), .sw_low(sw_low), .sw_zc(sw_zc),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic exp_hs, input logic exp_ls);
        n_chk++;
        if (hs_gate !== exp_hs || ls_gate !== exp_ls) begin
            n_fail++;
            $display("FAIL %s: hs/ls actual %b%b expected %b%b at %0t",
                     tag, hs_gate, ls_gate, exp_hs, exp_ls, $time);
        end
    endtask

    initial begin
        #(200000 * 20ns);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; disable_n = 0; supply_ok = 1; over_temp = 0;
        lsg_low = 1; sw_low = 1; sw_zc = 0; pwm_code = 2'b00; skip_code = 2'b10;
        adv(3);
        chk("R1 reset", 0, 0);
        rst_n = 1;
        adv(2);
        chk("R1 disabled", 0, 0);

        // R2 enable delay with PWM high
        pwm_code = 2'b10;
        adv(3);
        disable_n = 1;
        adv(EN + DH + 1);
        chk("R2 before enable", 0, 0);
        adv(1);
        chk("R2 after enable", 1, 0);

        // R6 high-to-low with sensed switch node already low
        pwm_code = 2'b00;
        adv(2);
        chk("R6 hs off", 0, 0);
        adv(DL);
        chk("R6 dead time", 0, 0);
        adv(1);
        chk("R6 ls on", 0, 1);

        // R5 low-to-high waiting on low-side gate sense
        lsg_low = 0;
        pwm_code = 2'b10;
        adv(2);
        chk("R5 ls off", 0, 0);
        adv(10);
        chk("R5 wait sense", 0, 0);
        lsg_low = 1;
        adv(DH);
        chk("R5 dead time", 0, 0);
        adv(1);
        chk("R5 hs on", 1, 0);

        // R6 waiting on switch-node sense
        sw_low = 0;
        pwm_code = 2'b00;
        adv(12);
        chk("R6 wait sense", 0, 0);
        sw_low = 1;
        adv(DL);
        chk("R6 dead time 2", 0, 0);
        adv(1);
        chk("R6 ls on 2", 0, 1);

        // R7 glitch shorter than holdoff, skip low
        skip_code = 2'b00;
        adv(2);
        pwm_code = 2'b01;
        for (int i = 0; i < H - 1; i++) begin
            adv(1);
            chk("R7 glitch", 0, 1);
        end
        pwm_code = 2'b00;
        adv(5);
        chk("R7 after glitch", 0, 1);

        // R9 tri-state, skip low
        pwm_code = 2'b01;
        adv(H);
        chk("R9 holdoff", 0, 1);
        adv(1);
        chk("R9 both off", 0, 0);

        // R8 diode emulation, early zero cross, PWM code 11
        skip_code = 2'b10;
        pwm_code = 2'b00;
        adv(10);
        chk("R8 setup", 0, 1);
        sw_zc = 1;
        pwm_code = 2'b11;
        adv(H + 1 + B);
        chk("R8 blanking", 0, 1);
        adv(1);
        chk("R8 zc off", 0, 0);

        // R8 late zero cross
        sw_zc = 0;
        pwm_code = 2'b00;
        adv(10);
        pwm_code = 2'b01;
        adv(H + B + 10);
        chk("R8 no zc", 0, 1);
        sw_zc = 1;
        adv(1);
        chk("R8 late zc", 0, 0);
        sw_zc = 0;

        // R10 skip frozen while high side on
        skip_code = 2'b00;
        pwm_code = 2'b00;
        adv(10);
        pwm_code = 2'b10;
        adv(10);
        chk("R10 hs on", 1, 0);
        skip_code = 2'b10;
        adv(3);
        pwm_code = 2'b01;
        adv(H + 12);
        chk("R10 frozen skip", 0, 0);

        // R11 faults
        pwm_code = 2'b00;
        adv(10);
        chk("R11 setup", 0, 1);
        supply_ok = 0;
        adv(1);
        chk("R11 supply", 0, 0);
        supply_ok = 1;
        adv(10);
        chk("R11 recover", 0, 1);
        over_temp = 1;
        adv(1);
        chk("R11 temp", 0, 0);
        over_temp = 0;
        adv(10);

        // R1 disable falling while high side on
        pwm_code = 2'b10;
        adv(10);
        chk("R1 pre", 1, 0);
        disable_n = 0;
        adv(1);
        chk("R1 disable", 0, 0);
        disable_n = 1;
        adv(EN + 10);

        // R3 / R4 sweep over all code pairs, no zero cross
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic eh, el;
                skip_code = 2'(s);
                pwm_code = 2'b00;
                adv(20);
                pwm_code = 2'(p);
                adv(40);
                if (p == 2)      begin eh = 1; el = 0; end
                else if (p == 0) begin eh = 0; el = 1; end
                else             begin eh = 0; el = (s == 0) ? 1'b0 : 1'b1; end
                chk("R3 sweep", eh, el);
                n_chk++;
                if (hs_gate && ls_gate) begin
                    n_fail++;
                    $display("FAIL R4 overlap: actual 11 expected not 11");
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule